// File: doc/BRIEF.md
# Filtered Power-Good Window Monitor

This block watches four supply rails through a single stream of digitized samples, each tagged with the index of the rail it belongs to. Each rail has a nominal value and its own under-voltage and over-voltage percentages. From these the block derives a lower and an upper threshold for that rail, and compares each incoming sample against both. The result for each rail is held until the next sample for that rail arrives.

The held comparator results feed glitch filters. The filters do not advance on every clock. They advance only on an update strobe, whose rate is set outside the block. A rail's filtered fault changes state only after the same new verdict has been seen on four successive strobes, so short excursions are dropped in both directions.

The filtered verdicts drive four outputs:
- an active-high power-good line, which is low while any rail is out of its window;
- a flag that separates over-voltage faults from under-voltage faults;
- a one-cycle interrupt request when power-good falls;
- a sticky per-rail capture vector, which the host clears by writing ones.

Top module: `pg_window_monitor`

## Requirements
- R1: After reset, pgood is 1, ov_flag is 0, pgood_irq is 0 and fault_cap is all zeros.
- R2: A rail's lower threshold is floor(nominal × (100 − uv_pct) / 100). A sample strictly below it gives an under-voltage verdict, and a sample equal to it does not.
- R3: A rail's upper threshold is floor(nominal × (100 + ov_pct) / 100). A sample strictly above it gives an over-voltage verdict, and a sample equal to it does not.
- R4: A percentage above 50 is treated as 50.
- R5: Filtered state changes only on a cycle where upd_stb is 1. Samples arriving between strobes only replace the held verdict of their rail.
- R6: A filtered fault sets only after four consecutive strobes on which the held verdict is a fault. A shorter run leaves pgood at 1 and raises no interrupt.
- R7: A filtered fault clears only after four consecutive strobes on which the held verdict is no fault. A single faulty strobe restarts the count.
- R8: pgood is the NOR of all filtered under- and over-voltage faults. It changes in the cycle right after the strobe that completes a run.
- R9: ov_flag is 1 exactly while some rail has a filtered over-voltage fault. An under-voltage fault alone leaves it at 0.
- R10: pgood_irq is a pulse of exactly one cycle in the cycle where pgood goes from 1 to 0. A rise of pgood gives no pulse.
- R11: fault_cap bit i (bit 0 is rail 0) sets one cycle after rail i shows a filtered fault. It stays set until fault_clr bit i is 1 while the fault is gone. If the clear arrives while the fault is present, the set wins.
- R12: smp_rail (2 bits, value i selects rail i) routes a sample to one rail only. The held verdicts of the other rails are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_nominal | input | 48 | Nominal value per rail, rail i in bits [12i+11:12i] |
| cfg_uv_pct | input | 28 | Under-voltage percentage per rail, rail i in bits [7i+6:7i] |
| cfg_ov_pct | input | 28 | Over-voltage percentage per rail, rail i in bits [7i+6:7i] |
| smp_valid | input | 1 | Sample present this cycle |
| smp_rail | input | 2 | Rail index of the sample |
| smp_data | input | 12 | Unsigned sample value |
| upd_stb | input | 1 | Filter update strobe |
| fault_clr | input | 4 | Write-one-to-clear for fault_cap |
| pgood | output | 1 | Power good, high when no filtered fault |
| ov_flag | output | 1 | Some rail has a filtered over-voltage fault |
| pgood_irq | output | 1 | One-cycle pulse on pgood falling |
| fault_cap | output | 4 | Sticky per-rail fault capture |

## Verification
The bench sweeps every rail through a set of percentages that includes 0, 50 and values above 50. For each one it drives samples one step past each threshold and exactly on it. This catches an off-by-one in the rounding, a comparison that is not strict, and a missing saturation. Runs of three faulty strobes, and recovery runs broken by a single bad strobe, are aimed at a filter whose count is too short, or one that never restarts its count. A design that lets samples alone move the filter, that leaks one rail's sample into another rail, that pulses the interrupt on recovery, or that lets a clear beat a live fault would each change pgood, the interrupt count or fault_cap at a checked point.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   localparam int unsigned PCT_SCALE = 100;

   typedef struct packed {
      logic uv;
      logic ov;
   } pgw_verdict_t;
endpackage

// File: rtl/pgw_thresh.sv
module pgw_thresh
   import pgw_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned PCT_W    = 7,
   parameter int unsigned PCT_MAX  = 50
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] nominal,
   input  logic [PCT_W-1:0]    uv_pct,
   input  logic [PCT_W-1:0]    ov_pct,
   output logic [SAMPLE_W:0]   uv_th,
   output logic [SAMPLE_W:0]   ov_th
);
   localparam int unsigned PROD_W = SAMPLE_W + 8;
   localparam int unsigned RES_W  = SAMPLE_W + 1;

   logic [PCT_W-1:0]  uv_sat, ov_sat;
   logic [PROD_W-1:0] uv_mult, ov_mult, uv_prod, ov_prod;

   always_comb begin
      uv_sat  = (uv_pct > PCT_W'(PCT_MAX)) ? PCT_W'(PCT_MAX) : uv_pct;
      ov_sat  = (ov_pct > PCT_W'(PCT_MAX)) ? PCT_W'(PCT_MAX) : ov_pct;
      uv_mult = PROD_W'(PCT_SCALE) - PROD_W'(uv_sat);
      ov_mult = PROD_W'(PCT_SCALE) + PROD_W'(ov_sat);
      uv_prod = PROD_W'(nominal) * uv_mult;
      ov_prod = PROD_W'(nominal) * ov_mult;
   end

   // thresholds are re-registered every cycle, so a new configuration is in use one cycle later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uv_th <= '0;
         ov_th <= '1;
      end else begin
         uv_th <= RES_W'(uv_prod / PROD_W'(PCT_SCALE));
         ov_th <= RES_W'(ov_prod / PROD_W'(PCT_SCALE));
      end
   end
endmodule

// File: rtl/pgw_rail_cmp.sv
module pgw_rail_cmp
   import pgw_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [SAMPLE_W:0]   uv_th,
   input  logic [SAMPLE_W:0]   ov_th,
   output pgw_verdict_t        verdict
);
   logic [SAMPLE_W:0] wide;

   assign wide = {1'b0, sample};

   // the verdict is held until the next sample that belongs to this rail
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         verdict <= '0;
      end else if (load) begin
         verdict.uv <= (wide < uv_th);
         verdict.ov <= (wide > ov_th);
      end
   end
endmodule

// File: rtl/pgw_glitch_filter.sv
module pgw_glitch_filter #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned STYLE = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic raw,
   output logic filt
);
   localparam int unsigned CNT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (STYLE == 0) begin : g_count
         logic [CNT_W-1:0] run_q;
         logic             state_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q   <= '0;
               state_q <= 1'b0;
            end else if (adv) begin
               if (raw == state_q) begin
                  run_q <= '0;
               end else if (run_q == CNT_W'(DEPTH - 1)) begin
                  state_q <= raw;
                  run_q   <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end
         end
         assign filt = state_q;
      end else begin : g_shift
         logic [DEPTH-1:0] hist_q;
         logic [DEPTH-1:0] hist_next;
         logic             state_q;

         assign hist_next = {hist_q[DEPTH-2:0], raw};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q  <= '0;
               state_q <= 1'b0;
            end else if (adv) begin
               hist_q <= hist_next;
               if (hist_next == {DEPTH{~state_q}}) state_q <= ~state_q;
            end
         end
         assign filt = state_q;
      end
   endgenerate
endmodule

// File: rtl/pg_window_monitor.sv
module pg_window_monitor
   import pgw_pkg::*;
#(
   parameter int unsigned NUM_RAILS  = 4,
   parameter int unsigned SAMPLE_W   = 12,
   parameter int unsigned PCT_W      = 7,
   parameter int unsigned PCT_MAX    = 50,
   parameter int unsigned FILT_DEPTH = 4,
   parameter int unsigned FILT_STYLE = 0,
   localparam int unsigned IDX_W     = $clog2(NUM_RAILS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_RAILS*SAMPLE_W-1:0] cfg_nominal,
   input  logic [NUM_RAILS*PCT_W-1:0]    cfg_uv_pct,
   input  logic [NUM_RAILS*PCT_W-1:0]    cfg_ov_pct,
   input  logic                          smp_valid,
   input  logic [IDX_W-1:0]              smp_rail,
   input  logic [SAMPLE_W-1:0]           smp_data,
   input  logic                          upd_stb,
   input  logic [NUM_RAILS-1:0]          fault_clr,
   output logic                          pgood,
   output logic                          ov_flag,
   output logic                          pgood_irq,
   output logic [NUM_RAILS-1:0]          fault_cap
);
   generate
      if (NUM_RAILS < 2) begin : g_bad_rails
         $error("NUM_RAILS must be at least 2");
      end
      if (FILT_DEPTH < 2) begin : g_bad_depth
         $error("FILT_DEPTH must be at least 2");
      end
      if (PCT_MAX >= PCT_SCALE || PCT_MAX >= (1 << PCT_W)) begin : g_bad_pct
         $error("PCT_MAX must be below 100 and fit in PCT_W bits");
      end
      if (FILT_STYLE > 1) begin : g_bad_style
         $error("FILT_STYLE must be 0 (counter) or 1 (shift history)");
      end
   endgenerate

   logic [NUM_RAILS-1:0] filt_uv, filt_ov, rail_fault;
   logic                 pgood_q;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_RAILS; gi++) begin : g_rail
         logic [SAMPLE_W:0] uv_th, ov_th;
         pgw_verdict_t      verdict;
         logic              hit;

         assign hit = smp_valid && (smp_rail == IDX_W'(gi));

         pgw_thresh #(
            .SAMPLE_W (SAMPLE_W),
            .PCT_W    (PCT_W),
            .PCT_MAX  (PCT_MAX)
         ) u_thresh (
            .clk     (clk),
            .rst_n   (rst_n),
            .nominal (cfg_nominal[gi*SAMPLE_W +: SAMPLE_W]),
            .uv_pct  (cfg_uv_pct[gi*PCT_W +: PCT_W]),
            .ov_pct  (cfg_ov_pct[gi*PCT_W +: PCT_W]),
            .uv_th   (uv_th),
            .ov_th   (ov_th)
         );

         pgw_rail_cmp #(
            .SAMPLE_W (SAMPLE_W)
         ) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (hit),
            .sample  (smp_data),
            .uv_th   (uv_th),
            .ov_th   (ov_th),
            .verdict (verdict)
         );

         pgw_glitch_filter #(
            .DEPTH (FILT_DEPTH),
            .STYLE (FILT_STYLE)
         ) u_filt_uv (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (upd_stb),
            .raw   (verdict.uv),
            .filt  (filt_uv[gi])
         );

         pgw_glitch_filter #(
            .DEPTH (FILT_DEPTH),
            .STYLE (FILT_STYLE)
         ) u_filt_ov (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (upd_stb),
            .raw   (verdict.ov),
            .filt  (filt_ov[gi])
         );

         assign rail_fault[gi] = filt_uv[gi] | filt_ov[gi];
      end
   endgenerate

   assign pgood     = ~(|filt_uv | |filt_ov);
   assign ov_flag   = |filt_ov;
   assign pgood_irq = pgood_q & ~pgood;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pgood_q   <= 1'b1;
         fault_cap <= '0;
      end else begin
         pgood_q   <= pgood;
         fault_cap <= (fault_cap & ~fault_clr) | rail_fault;
      end
   end
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
   parameter int unsigned NUM_RAILS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 upd_stb,
   input logic [NUM_RAILS-1:0] fault_clr,
   input logic                 pgood,
   input logic                 ov_flag,
   input logic                 pgood_irq,
   input logic [NUM_RAILS-1:0] fault_cap
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R9
   ovflag_pgood_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ov_flag |-> !pgood);

   // R10
   irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      pgood_irq |-> (!pgood && $past(pgood)));

   // R10
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pgood_irq |=> !pgood_irq);

   // R5
   stb_stable_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      !$past(upd_stb) |-> ($stable(pgood) && $stable(ov_flag)));

   // R11
   cap_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pgood |=> (fault_cap != '0));

   // R11
   cap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_clr == '0) |=> ((fault_cap & $past(fault_cap)) == $past(fault_cap)));
endmodule

bind pg_window_monitor pgw_checker #(.NUM_RAILS(NUM_RAILS)) u_pgw_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .upd_stb   (upd_stb),
   .fault_clr (fault_clr),
   .pgood     (pgood),
   .ov_flag   (ov_flag),
   .pgood_irq (pgood_irq),
   .fault_cap (fault_cap)
);

// File: tb/tb_pg_window_monitor.sv
module tb_pg_window_monitor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [47:0] cfg_nominal = '0;
   logic [27:0] cfg_uv_pct = '0;
   logic [27:0] cfg_ov_pct = '0;
   logic        smp_valid = 1'b0;
   logic [1:0]  smp_rail = '0;
   logic [11:0] smp_data = '0;
   logic        upd_stb = 1'b0;
   logic [3:0]  fault_clr = '0;
   logic        pgood, ov_flag, pgood_irq;
   logic [3:0]  fault_cap;

   int n_chk = 0;
   int n_fail = 0;
   int irq_seen = 0;

   always #4 clk = ~clk;

   pg_window_monitor dut (
      .clk(clk), .rst_n(rst_n), .cfg_nominal(cfg_nominal), .cfg_uv_pct(cfg_uv_pct),
      .cfg_ov_pct(cfg_ov_pct), .smp_valid(smp_valid), .smp_rail(smp_rail),
      .smp_data(smp_data), .upd_stb(upd_stb), .fault_clr(fault_clr),
      .pgood(pgood), .ov_flag(ov_flag), .pgood_irq(pgood_irq), .fault_cap(fault_cap)
   );

   always @(negedge clk) if (pgood_irq) irq_seen++;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_cfg(input int r, input int nom, input int uvp, input int ovp);
      cfg_nominal[r*12 +: 12] = 12'(nom);
      cfg_uv_pct[r*7 +: 7]    = 7'(uvp);
      cfg_ov_pct[r*7 +: 7]    = 7'(ovp);
      repeat (2) @(negedge clk);
   endtask

   task automatic send(input int r, input int d);
      smp_valid = 1'b1;
      smp_rail  = 2'(r);
      smp_data  = 12'(d);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic strobe();
      upd_stb = 1'b1;
      @(negedge clk);
      upd_stb = 1'b0;
      @(negedge clk);
   endtask

   task automatic clear(input logic [3:0] m);
      fault_clr = m;
      @(negedge clk);
      fault_clr = '0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int noms[4];
      int pcts[7];
      noms = '{4000, 1000, 2048, 37};
      pcts = '{0, 1, 6, 17, 33, 50, 90};
      for (int r = 0; r < 4; r++) begin
         cfg_nominal[r*12 +: 12] = 12'd2000;
         cfg_uv_pct[r*7 +: 7]    = 7'd6;
         cfg_ov_pct[r*7 +: 7]    = 7'd6;
      end
      repeat (5) @(negedge clk);
      chk("R1 pgood", int'(pgood), 1);
      chk("R1 ov_flag", int'(ov_flag), 0);
      chk("R1 irq", int'(pgood_irq), 0);
      chk("R1 fault_cap", int'(fault_cap), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // threshold sweep over every rail and a set of percentages (R2, R3, R4, R8, R9, R10, R11)
      for (int r = 0; r < 4; r++) begin
         for (int k = 0; k < 7; k++) begin
            int eff, uvt, ovt, irq0;
            string tag;
            eff = (pcts[k] > 50) ? 50 : pcts[k];
            tag = (pcts[k] > 50) ? "R4" : "";
            uvt = noms[r] * (100 - eff) / 100;
            ovt = noms[r] * (100 + eff) / 100;
            set_cfg(r, noms[r], pcts[k], pcts[k]);
            if (uvt > 0) begin
               irq0 = irq_seen;
               send(r, uvt - 1);
               repeat (3) strobe();
               chk({"R8 pgood before 4th strobe ", tag}, int'(pgood), 1);
               strobe();
               chk({"R2 uv fault ", tag}, int'(pgood), 0);
               chk("R9 ov_flag low on uv", int'(ov_flag), 0);
               chk("R10 irq on fall", irq_seen - irq0, 1);
               chk("R11 capture bit", int'(fault_cap[r]), 1);
               send(r, uvt);
               repeat (4) strobe();
               chk({"R2 on lower threshold ", tag}, int'(pgood), 1);
               chk("R10 no irq on rise", irq_seen - irq0, 1);
               clear(4'hF);
            end
            if (ovt + 1 <= 4095) begin
               send(r, ovt + 1);
               repeat (4) strobe();
               chk({"R3 ov fault ", tag}, int'(ov_flag), 1);
               chk("R8 pgood low on ov", int'(pgood), 0);
               send(r, ovt);
               repeat (4) strobe();
               chk({"R3 on upper threshold ", tag}, int'(pgood), 1);
               chk("R9 ov_flag cleared", int'(ov_flag), 0);
               clear(4'hF);
            end
         end
      end

      for (int r = 0; r < 4; r++) set_cfg(r, 2000, 6, 6); // window 1880..2120
      for (int r = 0; r < 4; r++) send(r, 2000);
      repeat (4) strobe();
      clear(4'hF);

      // R5: samples without strobes do nothing
      begin
         int irq0;
         irq0 = irq_seen;
         send(1, 100);
         repeat (12) @(negedge clk);
         chk("R5 no strobe no change", int'(pgood), 1);
         // R6: a run of three faulty strobes is dropped
         repeat (3) strobe();
         send(1, 2000);
         chk("R6 short run ignored", int'(pgood), 1);
         repeat (4) strobe();
         chk("R6 pgood stays high", int'(pgood), 1);
         chk("R6 no irq", irq_seen - irq0, 0);
         chk("R6 no capture", int'(fault_cap), 0);
      end

      // R7: recovery needs four clean strobes in a row
      send(2, 3000);
      repeat (4) strobe();
      chk("R7 fault set", int'(pgood), 0);
      send(2, 2000);
      repeat (3) strobe();
      send(2, 3000);
      strobe();
      send(2, 2000);
      repeat (3) strobe();
      chk("R7 interrupted recovery", int'(pgood), 0);
      strobe();
      chk("R7 recovered", int'(pgood), 1);
      clear(4'hF);

      // R12: sample routing; R11 set wins and stickiness
      send(3, 10);
      send(0, 2000);
      send(0, 2001);
      repeat (4) strobe();
      chk("R12 rail 3 kept its verdict", int'(fault_cap), 8);
      clear(4'h8);
      chk("R11 set wins over clear", int'(fault_cap), 8);
      send(1, 4000);
      repeat (4) strobe();
      @(negedge clk);
      chk("R11 two rails captured", int'(fault_cap), 10);
      chk("R9 ov from rail 1", int'(ov_flag), 1);
      send(1, 2000);
      send(3, 2000);
      repeat (4) strobe();
      chk("R11 sticky after recovery", int'(fault_cap), 10);
      chk("R8 all clear", int'(pgood), 1);
      clear(4'h2);
      chk("R11 partial clear", int'(fault_cap), 8);
      clear(4'h8);
      chk("R11 full clear", int'(fault_cap), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule